// File: doc/BRIEF.md
# Flash Command and Lock Sequencer

This block accepts commands for a page-organised non-volatile array through one 32-bit command word and runs them. The commands are:

- program a page, either after an automatic erase or as a bit-clearing program into an unerased page;
- erase one page, or erase the whole array;
- set or clear a per-region write-protection bit;
- set or clear one of three general-purpose configuration bits;
- set the security bit.

Every command word carries an 8-bit protection key in its top byte. Malformed commands, commands with a wrong key and commands written while the block is busy are flagged as forbidden. Erase and program commands are checked against the region protection bits, and a command that would touch a protected region ends at once as aborted. Sticky status flags report completion and errors. A combined interrupt line can be enabled separately for completion and for errors.

The array is a behavioural model holding one data word per page. It keeps each operation busy for a cycle count given on input ports, and it serves reads with zero to three wait states. A rising edge on the external forced-erase input clears all protection and configuration bits at once. It then runs a full-array erase, and clears the security bit when that erase ends. The calibration value is never changed.

The controller has three states. IDLE waits for a command. RUN counts out a command's duration. FORCE counts out the forced erase. The transitions are:

- IDLE→RUN when a command is accepted.
- RUN→IDLE when the command duration expires.
- FORCE→IDLE when the full-erase duration expires.
- Any state →FORCE on a rising edge of the erase input. This edge also abandons a running command.

Top module: `nvm_cmd_seq`

## Requirements
- R1: A command word is executed only if bits [31:24] equal 0x5A and all reserved bits ([23:18] and [7:4] with the default 10-bit page field) are zero. Otherwise `key_err` is set and `busy` stays low.
- R2: An accepted command holds `busy` high for exactly the cycle count on its duration port:
  - program with erase uses `t_prog_erase`;
  - program without erase uses `t_prog`;
  - page erase uses `t_page_erase`;
  - full erase uses `t_full`;
  - the lock, general-purpose and security commands use `t_bit`.
  
  A count of zero behaves as one.
- R3: The opcode sits in bits [3:0] and the page in bits [17:8]. The opcodes that change the array are:
  - 1, program with erase, writes the page word with `wbuf_data` as sampled at acceptance;
  - 2, program without erase, leaves the bitwise AND of old and new;
  - 3, page erase, sets the page word to all ones;
  - 4, full erase, sets every page to all ones.
- R4: Opcodes 1–3 aimed at a page whose region (page / 64) is protected are aborted: `busy` stays low, `lock_err` and `cmd_done` are set, and the page is unchanged. Opcode 4 is aborted the same way while any region is protected.
- R5: Opcode 5 sets, and opcode 6 clears, the protection bit of region (page field / 64). Region n is bit n of `lock_bits`.
- R6: A command write while `busy` is high is rejected with `key_err`, and the running command completes with its own effect.
- R7: Opcodes 0 and 10–15, and general-purpose commands with an index above 2, are forbidden (`key_err`).
- R8: Opcode 7 sets, and opcode 8 clears, bit (page field) of `gp_bits`, for indexes 0 to 2.
- R9: Opcode 9 sets `secure`. No command clears it; it falls only when a forced erase completes.
- R10: A rising edge of `erase_pin` clears `lock_bits` and `gp_bits` on the next cycle and holds `busy` for `t_full` cycles. After that every page reads all ones, `secure` is 0 and `calib` is unchanged.
- R11: `irq` = (`cmd_done` & `ie_done`) | ((`lock_err` | `key_err`) & `ie_err`).
- R12: A read accepted with `rd_en` returns `rd_valid` with the page word `rd_ws`+1 cycles later.
- R13: Each command write seen in IDLE first clears `cmd_done`, `lock_err` and `key_err`, then sets them by its own outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_word | input | 32 | Key, page field and opcode |
| wbuf_data | input | 8 | Write buffer word used by program commands |
| t_prog_erase | input | 16 | Cycles for program with erase |
| t_prog | input | 16 | Cycles for program without erase |
| t_page_erase | input | 16 | Cycles for page erase |
| t_full | input | 16 | Cycles for full erase and forced erase |
| t_bit | input | 16 | Cycles for lock, general-purpose and security commands |
| ie_done | input | 1 | Interrupt enable for completion |
| ie_err | input | 1 | Interrupt enable for errors |
| erase_pin | input | 1 | External forced-erase request |
| rd_en | input | 1 | Read request |
| rd_page | input | 10 | Page to read |
| rd_ws | input | 2 | Read wait states |
| busy | output | 1 | Command or forced erase in progress |
| cmd_done | output | 1 | Last command ended |
| lock_err | output | 1 | Last command aborted by protection |
| key_err | output | 1 | Forbidden command |
| irq | output | 1 | Combined interrupt |
| lock_bits | output | 16 | Region protection bits |
| gp_bits | output | 3 | General-purpose configuration bits |
| secure | output | 1 | Security bit |
| calib | output | 8 | Calibration value |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 8 | Read data |

## Verification
The assertions watch, on every cycle, several behaviours:
- a bad key never starts a command;
- a write during `busy` always raises `key_err`;
- an aborted protected-region command never raises `busy`;
- `secure` falls only on leaving the forced-erase state;
- an erase-pin edge clears the protection and configuration bits on the next cycle;
- a zero-wait read answers one cycle later.

Only the bench scenarios can show the rest:
- the exact busy durations per opcode;
- the data left in pages after program, AND-program and erase;
- that a rejected or aborted command leaves the array untouched;
- that the calibration value survives a forced erase;
- the interrupt gating.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;
    localparam logic [3:0] OP_PROG_ERASE = 4'd1;
    localparam logic [3:0] OP_PROG       = 4'd2;
    localparam logic [3:0] OP_PAGE_ERASE = 4'd3;
    localparam logic [3:0] OP_FULL_ERASE = 4'd4;
    localparam logic [3:0] OP_LOCK_SET   = 4'd5;
    localparam logic [3:0] OP_LOCK_CLR   = 4'd6;
    localparam logic [3:0] OP_GP_SET     = 4'd7;
    localparam logic [3:0] OP_GP_CLR     = 4'd8;
    localparam logic [3:0] OP_SEC_SET    = 4'd9;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_RUN   = 2'd1,
        S_FORCE = 2'd2
    } seq_state_e;

    typedef enum logic [2:0] {
        A_NONE       = 3'd0,
        A_WRITE      = 3'd1,
        A_AND        = 3'd2,
        A_ERASE_PAGE = 3'd3,
        A_ERASE_ALL  = 3'd4
    } arr_op_e;
endpackage

// File: rtl/nvm_cmd_decode.sv
module nvm_cmd_decode
    import nvm_seq_pkg::*;
#(
    parameter int PAGE_W  = 10,
    parameter int REGIONS = 16,
    parameter int RSH     = 6,
    parameter int CNT_W   = 16,
    parameter logic [7:0] KEY = 8'h5A
) (
    input  logic [31:0]        cmd_word,
    input  logic [REGIONS-1:0] lock_bits,
    input  logic [CNT_W-1:0]   t_prog_erase,
    input  logic [CNT_W-1:0]   t_prog,
    input  logic [CNT_W-1:0]   t_page_erase,
    input  logic [CNT_W-1:0]   t_full,
    input  logic [CNT_W-1:0]   t_bit,
    output logic               key_ok,
    output logic               op_legal,
    output logic               hits_lock,
    output logic [3:0]         op,
    output logic [PAGE_W-1:0]  page,
    output logic [CNT_W-1:0]   dur
);
    localparam logic [31:0] FIELD_MASK =
        32'hFF00_0000 | (((32'd1 << PAGE_W) - 32'd1) << 8) | 32'h0000_000F;
    localparam int REG_W = PAGE_W - RSH;

    logic             rsv_ok;
    logic [REG_W-1:0] region;

    assign op     = cmd_word[3:0];
    assign page   = cmd_word[8 +: PAGE_W];
    assign region = page[PAGE_W-1:RSH];
    assign rsv_ok = ((cmd_word & ~FIELD_MASK) == 32'd0);
    assign key_ok = (cmd_word[31:24] == KEY) && rsv_ok;

    always_comb begin
        op_legal  = 1'b1;
        hits_lock = 1'b0;
        dur       = t_bit;
        unique case (op)
            OP_PROG_ERASE: begin dur = t_prog_erase; hits_lock = lock_bits[region]; end
            OP_PROG:       begin dur = t_prog;       hits_lock = lock_bits[region]; end
            OP_PAGE_ERASE: begin dur = t_page_erase; hits_lock = lock_bits[region]; end
            OP_FULL_ERASE: begin dur = t_full;       hits_lock = |lock_bits;        end
            OP_LOCK_SET, OP_LOCK_CLR, OP_SEC_SET: dur = t_bit;
            OP_GP_SET, OP_GP_CLR: op_legal = (page < PAGE_W'(3));
            default: op_legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/nvm_timer.sv
module nvm_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - CNT_W'(1);
    end

    assign last = (cnt <= CNT_W'(1));
endmodule

// File: rtl/nvm_page_array.sv
module nvm_page_array
    import nvm_seq_pkg::*;
#(
    parameter int PAGES  = 1024,
    parameter int PAGE_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  arr_op_e           wr_op,
    input  logic [PAGE_W-1:0] wr_page,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [PAGE_W-1:0] rd_page,
    input  logic [1:0]        rd_ws,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [PAGES];
    logic              pend;
    logic [1:0]        wcnt;
    logic [PAGE_W-1:0] rpage;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGES; i++) mem[i] <= '1;
            pend     <= 1'b0;
            wcnt     <= '0;
            rpage    <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            unique case (wr_op)
                A_WRITE:      mem[wr_page] <= wr_data;
                A_AND:        mem[wr_page] <= mem[wr_page] & wr_data;
                A_ERASE_PAGE: mem[wr_page] <= '1;
                A_ERASE_ALL:  for (int i = 0; i < PAGES; i++) mem[i] <= '1;
                default: ;
            endcase
            if (pend) begin
                if (wcnt == 2'd1) begin
                    rd_valid <= 1'b1;
                    rd_data  <= mem[rpage];
                    pend     <= 1'b0;
                end else begin
                    wcnt <= wcnt - 2'd1;
                end
            end else if (rd_en) begin
                if (rd_ws == 2'd0) begin
                    rd_valid <= 1'b1;
                    rd_data  <= mem[rd_page];
                end else begin
                    pend  <= 1'b1;
                    wcnt  <= rd_ws;
                    rpage <= rd_page;
                end
            end
        end
    end

    // R12: a read with no wait states answers on the following cycle
    p_read_zero_ws_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !pend && rd_ws == 2'd0) |=> rd_valid);
endmodule

// File: rtl/nvm_cmd_seq.sv
module nvm_cmd_seq
    import nvm_seq_pkg::*;
#(
    parameter int PAGES            = 1024,
    parameter int PAGES_PER_REGION = 64,
    parameter int DATA_W           = 8,
    parameter int CNT_W            = 16,
    parameter int CALIB_W          = 8,
    parameter logic [CALIB_W-1:0] CALIB_INIT = 8'hA5,
    parameter logic [7:0] KEY      = 8'h5A,
    localparam int PAGE_W          = $clog2(PAGES),
    localparam int REGIONS         = PAGES / PAGES_PER_REGION
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_we,
    input  logic [31:0]        cmd_word,
    input  logic [DATA_W-1:0]  wbuf_data,
    input  logic [CNT_W-1:0]   t_prog_erase,
    input  logic [CNT_W-1:0]   t_prog,
    input  logic [CNT_W-1:0]   t_page_erase,
    input  logic [CNT_W-1:0]   t_full,
    input  logic [CNT_W-1:0]   t_bit,
    input  logic               ie_done,
    input  logic               ie_err,
    input  logic               erase_pin,
    input  logic               rd_en,
    input  logic [PAGE_W-1:0]  rd_page,
    input  logic [1:0]         rd_ws,
    output logic               busy,
    output logic               cmd_done,
    output logic               lock_err,
    output logic               key_err,
    output logic               irq,
    output logic [REGIONS-1:0] lock_bits,
    output logic [2:0]         gp_bits,
    output logic               secure,
    output logic [CALIB_W-1:0] calib,
    output logic               rd_valid,
    output logic [DATA_W-1:0]  rd_data
);
    localparam int RSH = $clog2(PAGES_PER_REGION);

    seq_state_e        state, state_nx;
    logic              erase_q, force_start;
    logic              key_ok, op_legal, hits_lock, accept, last;
    logic [3:0]        dec_op, cur_op;
    logic [PAGE_W-1:0] dec_page, cur_page;
    logic [CNT_W-1:0]  dec_dur;
    logic [DATA_W-1:0] cur_data;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    arr_op_e           arr_op;

    nvm_cmd_decode #(
        .PAGE_W(PAGE_W), .REGIONS(REGIONS), .RSH(RSH), .CNT_W(CNT_W), .KEY(KEY)
    ) u_dec (
        .cmd_word(cmd_word), .lock_bits(lock_bits),
        .t_prog_erase(t_prog_erase), .t_prog(t_prog), .t_page_erase(t_page_erase),
        .t_full(t_full), .t_bit(t_bit),
        .key_ok(key_ok), .op_legal(op_legal), .hits_lock(hits_lock),
        .op(dec_op), .page(dec_page), .dur(dec_dur)
    );

    assign force_start = erase_pin && !erase_q;
    assign accept      = (state == S_IDLE) && cmd_we && !force_start
                         && key_ok && op_legal && !hits_lock;
    assign tmr_load    = force_start || accept;
    assign tmr_val     = force_start ? t_full : dec_dur;

    nvm_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .last(last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        if (force_start) begin
            state_nx = S_FORCE;
        end else begin
            unique case (state)
                S_IDLE:  if (accept) state_nx = S_RUN;
                S_RUN:   if (last)   state_nx = S_IDLE;
                S_FORCE: if (last)   state_nx = S_IDLE;
                default: state_nx = S_IDLE;
            endcase
        end
    end

    // Array operation issued on the finishing cycle
    always_comb begin
        arr_op = A_NONE;
        if (!force_start && last) begin
            unique case (state)
                S_RUN: begin
                    unique case (cur_op)
                        OP_PROG_ERASE: arr_op = A_WRITE;
                        OP_PROG:       arr_op = A_AND;
                        OP_PAGE_ERASE: arr_op = A_ERASE_PAGE;
                        OP_FULL_ERASE: arr_op = A_ERASE_ALL;
                        default:       arr_op = A_NONE;
                    endcase
                end
                S_FORCE: arr_op = A_ERASE_ALL;
                default: arr_op = A_NONE;
            endcase
        end
    end

    // Protection state, status flags and command latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            erase_q   <= 1'b0;
            lock_bits <= '0;
            gp_bits   <= '0;
            secure    <= 1'b0;
            cmd_done  <= 1'b0;
            lock_err  <= 1'b0;
            key_err   <= 1'b0;
            cur_op    <= '0;
            cur_page  <= '0;
            cur_data  <= '0;
        end else begin
            erase_q <= erase_pin;
            if (force_start) begin
                lock_bits <= '0;
                gp_bits   <= '0;
            end else begin
                unique case (state)
                    S_IDLE: begin
                        if (cmd_we) begin
                            cmd_done <= 1'b0;
                            lock_err <= 1'b0;
                            key_err  <= 1'b0;
                            if (!key_ok || !op_legal) begin
                                key_err <= 1'b1;
                            end else if (hits_lock) begin
                                lock_err <= 1'b1;
                                cmd_done <= 1'b1;
                            end else begin
                                cur_op   <= dec_op;
                                cur_page <= dec_page;
                                cur_data <= wbuf_data;
                            end
                        end
                    end
                    S_RUN: begin
                        if (cmd_we) key_err <= 1'b1;
                        if (last) begin
                            cmd_done <= 1'b1;
                            unique case (cur_op)
                                OP_LOCK_SET: lock_bits[cur_page[PAGE_W-1:RSH]] <= 1'b1;
                                OP_LOCK_CLR: lock_bits[cur_page[PAGE_W-1:RSH]] <= 1'b0;
                                OP_GP_SET:   gp_bits[cur_page[1:0]] <= 1'b1;
                                OP_GP_CLR:   gp_bits[cur_page[1:0]] <= 1'b0;
                                OP_SEC_SET:  secure <= 1'b1;
                                default: ;
                            endcase
                        end
                    end
                    S_FORCE: begin
                        if (cmd_we) key_err <= 1'b1;
                        if (last) begin
                            secure   <= 1'b0;
                            cmd_done <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    nvm_page_array #(.PAGES(PAGES), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_arr (
        .clk(clk), .rst_n(rst_n),
        .wr_op(arr_op), .wr_page(cur_page), .wr_data(cur_data),
        .rd_en(rd_en), .rd_page(rd_page), .rd_ws(rd_ws),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    assign busy  = (state != S_IDLE);
    assign calib = CALIB_INIT;
    assign irq   = (cmd_done && ie_done) || ((lock_err || key_err) && ie_err);

    // R1: a wrong key never starts a command
    p_bad_key_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && cmd_we && !force_start && cmd_word[31:24] != KEY)
        |=> (key_err && !busy));

    // R4: a protected-region command is aborted without going busy
    p_lock_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && cmd_we && !force_start && key_ok && op_legal && hits_lock)
        |=> (!busy && lock_err && cmd_done));

    // R6: a write during a running command is flagged
    p_busy_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_we && !force_start) |=> key_err);

    // R9: the security bit falls only when leaving the forced erase
    p_sec_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(secure) |-> ($past(state) == S_FORCE));

    // R10: an erase-pin edge clears protection and configuration bits
    p_force_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erase_pin) |=> (lock_bits == '0 && gp_bits == '0 && busy));
endmodule

// File: tb/tb_nvm_cmd_seq.sv
module tb_nvm_cmd_seq;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] KEY = 8'h5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [31:0] cmd_word = '0;
    logic [7:0]  wbuf_data = '0;
    logic [15:0] t_prog_erase = 16'd12, t_prog = 16'd6, t_page_erase = 16'd5;
    logic [15:0] t_full = 16'd20, t_bit = 16'd3;
    logic        ie_done = 1'b0, ie_err = 1'b0, erase_pin = 1'b0, rd_en = 1'b0;
    logic [9:0]  rd_page = '0;
    logic [1:0]  rd_ws = 2'd0;
    logic        busy, cmd_done, lock_err, key_err, irq, secure, rd_valid;
    logic [15:0] lock_bits;
    logic [2:0]  gp_bits;
    logic [7:0]  calib, rd_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    nvm_cmd_seq dut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_word(cmd_word),
        .wbuf_data(wbuf_data), .t_prog_erase(t_prog_erase), .t_prog(t_prog),
        .t_page_erase(t_page_erase), .t_full(t_full), .t_bit(t_bit),
        .ie_done(ie_done), .ie_err(ie_err), .erase_pin(erase_pin),
        .rd_en(rd_en), .rd_page(rd_page), .rd_ws(rd_ws),
        .busy(busy), .cmd_done(cmd_done), .lock_err(lock_err), .key_err(key_err),
        .irq(irq), .lock_bits(lock_bits), .gp_bits(gp_bits), .secure(secure),
        .calib(calib), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] cw(input logic [3:0] op, input logic [9:0] pg);
        return {KEY, 6'd0, pg, 4'd0, op};
    endfunction

    task automatic issue(input logic [31:0] w);
        @(negedge clk);
        cmd_we = 1'b1;
        cmd_word = w;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic rd(input logic [9:0] pg, output logic [7:0] d, output int lat);
        @(negedge clk);
        rd_en = 1'b1;
        rd_page = pg;
        @(negedge clk);
        rd_en = 1'b0;
        lat = 1;
        while (!rd_valid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        d = rd_data;
    endtask

    task automatic run(input logic [31:0] w, output int n);
        issue(w);
        wait_idle(n);
    endtask

    task automatic t_reset;
        logic [7:0] d; int l;
        chk("R13 reset busy", busy, 0);
        chk("R13 reset flags", {cmd_done, lock_err, key_err, irq}, 0);
        chk("R5 reset locks", lock_bits, 0);
        chk("R8 reset gp", gp_bits, 0);
        chk("R9 reset secure", secure, 0);
        rd(10'd5, d, l);
        chk("R3 erased at reset", d, 8'hFF);
    endtask

    task automatic t_bad_key;
        logic [7:0] d; int l;
        wbuf_data = 8'h00;
        issue({8'h11, cw(4'd1, 10'd3)} [31:0] & 32'h00FF_FFFF | 32'h1100_0000);
        chk("R1 bad key flag", key_err, 1);
        chk("R1 bad key not busy", busy, 0);
        issue(cw(4'd1, 10'd3) | 32'h0000_0040);
        chk("R1 reserved bit flag", key_err, 1);
        chk("R1 reserved not busy", busy, 0);
        rd(10'd3, d, l);
        chk("R1 page untouched", d, 8'hFF);
    endtask

    task automatic t_program;
        logic [7:0] d; int n, l;
        wbuf_data = 8'h3C;
        run(cw(4'd1, 10'd3), n);
        chk("R2 prog-erase cycles", n, 12);
        chk("R13 done set, key_err cleared", {cmd_done, key_err}, 2'b10);
        wbuf_data = 8'h00;
        rd(10'd3, d, l);
        chk("R3 program with erase", d, 8'h3C);
        wbuf_data = 8'hF0;
        run(cw(4'd2, 10'd3), n);
        chk("R2 prog cycles", n, 6);
        rd(10'd3, d, l);
        chk("R3 program AND", d, 8'h30);
        run(cw(4'd3, 10'd3), n);
        chk("R2 page erase cycles", n, 5);
        rd(10'd3, d, l);
        chk("R3 page erase", d, 8'hFF);
    endtask

    task automatic t_lock;
        logic [7:0] d; int n, l;
        run(cw(4'd5, 10'd70), n);
        chk("R2 lock cycles", n, 3);
        chk("R5 lock region 1", lock_bits, 16'h0002);
        wbuf_data = 8'h00;
        issue(cw(4'd1, 10'd100));
        chk("R4 locked program not busy", busy, 0);
        chk("R4 locked program flags", {cmd_done, lock_err}, 2'b11);
        rd(10'd100, d, l);
        chk("R4 locked page unchanged", d, 8'hFF);
        issue(cw(4'd4, 10'd0));
        chk("R4 full erase blocked", {busy, lock_err}, 2'b01);
        run(cw(4'd6, 10'd64), n);
        chk("R5 lock cleared", lock_bits, 16'h0000);
        run(cw(4'd1, 10'd100), n);
        rd(10'd100, d, l);
        chk("R5 unlocked page programmed", d, 8'h00);
    endtask

    task automatic t_busy_reject;
        logic [7:0] d; int n, l;
        wbuf_data = 8'h81;
        issue(cw(4'd1, 10'd7));
        cmd_we = 1'b1;
        cmd_word = cw(4'd7, 10'd1);
        @(negedge clk);
        cmd_we = 1'b0;
        wait_idle(n);
        chk("R6 busy write flagged", {key_err, cmd_done}, 2'b11);
        chk("R6 rejected gp write ignored", gp_bits, 3'b000);
        rd(10'd7, d, l);
        chk("R6 running program completes", d, 8'h81);
    endtask

    task automatic t_invalid_and_gp;
        int n;
        issue(cw(4'd15, 10'd0));
        chk("R7 opcode 15 forbidden", {key_err, busy}, 2'b10);
        issue(cw(4'd7, 10'd3));
        chk("R7 gp index 3 forbidden", {key_err, busy}, 2'b10);
        run(cw(4'd7, 10'd0), n);
        chk("R13 key_err cleared by next command", key_err, 0);
        run(cw(4'd7, 10'd2), n);
        chk("R8 gp set", gp_bits, 3'b101);
        run(cw(4'd8, 10'd0), n);
        chk("R8 gp clear", gp_bits, 3'b100);
    endtask

    task automatic t_secure_irq;
        int n;
        run(cw(4'd9, 10'd0), n);
        chk("R9 secure set", secure, 1);
        issue(cw(4'd10, 10'd0));
        chk("R9 no clear command", {secure, key_err}, 2'b11);
        ie_done = 1'b0; ie_err = 1'b0;
        @(negedge clk);
        chk("R11 irq masked", irq, 0);
        ie_err = 1'b1;
        @(negedge clk);
        chk("R11 irq on error", irq, 1);
        ie_err = 1'b0;
        run(cw(4'd8, 10'd1), n);
        chk("R11 done masked", irq, 0);
        ie_done = 1'b1;
        @(negedge clk);
        chk("R11 irq on done", irq, 1);
        ie_done = 1'b0;
    endtask

    task automatic t_force;
        logic [7:0] d; int n, l;
        wbuf_data = 8'h55;
        run(cw(4'd1, 10'd200), n);
        run(cw(4'd5, 10'd200), n);
        chk("R5 lock region 3", lock_bits, 16'h0008);
        @(negedge clk);
        erase_pin = 1'b1;
        @(negedge clk);
        chk("R10 locks cleared at once", lock_bits, 0);
        chk("R10 gp cleared at once", gp_bits, 0);
        chk("R10 secure held during erase", {busy, secure}, 2'b11);
        wait_idle(n);
        chk("R10 forced erase cycles", n, 20);
        chk("R9 secure cleared after erase", secure, 0);
        erase_pin = 1'b0;
        rd(10'd200, d, l);
        chk("R10 page 200 erased", d, 8'hFF);
        rd(10'd7, d, l);
        chk("R10 page 7 erased", d, 8'hFF);
        chk("R10 calibration kept", calib, 8'hA5);
    endtask

    task automatic t_full_erase;
        logic [7:0] d; int n, l;
        wbuf_data = 8'h12;
        run(cw(4'd1, 10'd9), n);
        run(cw(4'd4, 10'd0), n);
        chk("R2 full erase cycles", n, 20);
        rd(10'd9, d, l);
        chk("R3 full erase", d, 8'hFF);
    endtask

    task automatic t_read_ws;
        logic [7:0] d; int l;
        rd_ws = 2'd3;
        rd(10'd1, d, l);
        chk("R12 latency ws=3", l, 4);
        rd_ws = 2'd2;
        rd(10'd1, d, l);
        chk("R12 latency ws=2", l, 3);
        rd_ws = 2'd0;
        rd(10'd1, d, l);
        chk("R12 latency ws=0", l, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bad_key();
        t_program();
        t_lock();
        t_busy_reject();
        t_invalid_and_gp();
        t_secure_irq();
        t_force();
        t_full_erase();
        t_read_ws();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule